// File: doc/BRIEF.md
# Multi-Format Serial Result Output Port

This block holds the latest 16-bit result delivered by an internal producer and shifts it out on one serial data line when a host pulls chip-select low. The producer hands over each new word with a single-cycle load strobe and a 16-bit data bus. A two-bit format input selects how the word leaves. The first format is byte-framed and asynchronous, with a start bit and two stop bits around each byte. The second is a raw synchronous stream clocked by a serial clock that the host drives. The third is a raw synchronous stream with a serial clock that the block generates itself from the master clock.

An active-low data-ready output tells the host when an unread, valid word is waiting. Each load marks the output as not ready for a short, fixed blanking window. This also happens while a word is being shifted out. A transfer that finishes normally clears the ready state. The exception is a newer word that arrived while the old one was still going out: that newer word stays pending. Releasing chip-select in the middle of a word abandons it, and the next selection starts the word again from its first bit.

Top module: `serial_result_port`

## Requirements
- R1: After reset, drdy_n is 1 and sclk_out is 0. With fmt_sel = 00, sdata is 1 and sclk_oe is 0.
- R2: A load (load_valid high at a clock edge) captures load_data. drdy_n is then 1 for exactly four clock cycles starting at that edge, and 0 afterwards. This holds even while a transfer is in progress.
- R3: A transfer begins only at a clock edge where cs_n is 0 and drdy_n is 0. If cs_n goes low while drdy_n is 1, the block waits and the transfer begins at the first edge after drdy_n falls.
- R4: With fmt_sel = 00 the word goes out as 22 bits. The upper byte is sent first, then the lower byte. Each byte is a 0 start bit, eight data bits least significant first, and two 1 stop bits. Each bit lasts one sclk_in period and changes after a falling edge of sclk_in. sdata idles at 1 in this format.
- R5: With fmt_sel = 01 or 11 the word goes out as 16 bits, most significant first, with no framing. sclk_in passes through a two-flop synchroniser. The bit changes a few master cycles after each sclk_in falling edge and is stable at the next rising edge. sdata idles at 0 in these formats.
- R6: With fmt_sel = 10, sclk_oe is 1 and the block drives sclk_out. sclk_out has a period of four master cycles and is high for one cycle in four. The 16 bits go out most significant first, change while sclk_out is low, and are stable at each rising edge.
- R7: When the last bit of a word ends, drdy_n goes to 1. The exception is a word loaded after that transfer began: drdy_n then stays 0 once that load's blanking ends.
- R8: Loading a word during a transfer does not change any bit of the word being sent. The next transfer sends the newly loaded word.
- R9: Raising cs_n in the middle of a word aborts it. sdata returns to its idle level, sclk_out stays low and drdy_n is unchanged. The next cs_n low restarts the word from its first bit.
- R10: After a word completes with cs_n held low, no new transfer starts until cs_n has returned to 1, even if a new word becomes ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Strobe: capture load_data as the new result |
| load_data | input | 16 | New result word |
| fmt_sel | input | 2 | 00 framed async, 01/11 external-clock sync, 10 self-clocked sync |
| cs_n | input | 1 | Active-low select; low starts or continues a transfer |
| sclk_in | input | 1 | Serial clock from the host (formats 00, 01, 11) |
| sclk_out | output | 1 | Generated serial clock (format 10) |
| sclk_oe | output | 1 | High when the block drives the serial clock pin |
| sdata | output | 1 | Serial data line |
| drdy_n | output | 1 | Active-low data ready |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a four-cycle blanking window, a two-flop synchroniser and a divide-by-four generated clock. With these values it can check exact 22-bit framed streams and 16-bit raw streams bit by bit. It can also check the one-in-four duty and the four-cycle period of the generated clock, and the exact edges of the blanking window. The short word and small divider also let the bench place loads, aborts and re-selections at chosen bit positions inside a word.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        FMT_ASYNC = 2'b00,
        FMT_EXT   = 2'b01,
        FMT_SELF  = 2'b10,
        FMT_EXT2  = 2'b11
    } fmt_e;

    localparam int unsigned STOP_BITS = 2;
    localparam int unsigned BYTE_SLOT = 1 + 8 + STOP_BITS;

endpackage

// File: rtl/srp_edge_sync.sv
module srp_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES:0] pipe;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // oldest stage high, synchronised stage low: one-cycle falling pulse
    assign fall_o = s_q.pipe[STAGES] & ~s_q.pipe[STAGES-1];

endmodule

// File: rtl/srp_frame_build.sv
module srp_frame_build
    import srp_pkg::*;
#(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned FRAME_W = 22,
    parameter int unsigned CNT_W   = 5
) (
    input  logic [WORD_W-1:0]  word_i,
    input  logic [1:0]         fmt_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   last_o
);

    localparam int unsigned NBYTES = WORD_W / 8;

    logic [FRAME_W-1:0] framed;
    logic [FRAME_W-1:0] raw;

    // slot k leaves k-th; slot 0 carries the most significant byte
    for (genvar k = 0; k < NBYTES; k++) begin : g_slot
        localparam int unsigned BASE = k * BYTE_SLOT;
        localparam int unsigned SRC  = (NBYTES - 1 - k) * 8;
        assign framed[BASE]                        = 1'b0;
        assign framed[BASE+8:BASE+1]               = word_i[SRC+7:SRC];
        assign framed[BASE+BYTE_SLOT-1:BASE+9]     = '1;
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < WORD_W; i++) begin
            raw[i] = word_i[WORD_W-1-i];
        end
    end

    always_comb begin
        if (fmt_i == FMT_ASYNC) begin
            frame_o = framed;
            last_o  = CNT_W'(FRAME_W - 1);
        end else begin
            frame_o = raw;
            last_o  = CNT_W'(WORD_W - 1);
        end
    end

endmodule

// File: rtl/srp_ready_track.sv
module srp_ready_track #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned BLANK_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              start_i,
    input  logic              done_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ready_o
);

    localparam int unsigned BL_W = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              newer;
        logic [BL_W-1:0]   blank;
    } trk_st_t;

    trk_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.blank != '0) s_d.blank = s_q.blank - BL_W'(1);
        if (start_i)         s_d.newer = 1'b0;
        if (done_i && !s_q.newer) s_d.valid = 1'b0;
        if (load_i) begin
            s_d.word  = data_i;
            s_d.valid = 1'b1;
            s_d.newer = 1'b1;
            s_d.blank = BL_W'(BLANK_CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o  = s_q.word;
    assign ready_o = s_q.valid && (s_q.blank == '0);

endmodule

// File: rtl/srp_shifter.sv
module srp_shifter
    import srp_pkg::*;
#(
    parameter int unsigned FRAME_W = 22,
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_i,
    input  logic               ready_i,
    input  logic [1:0]         fmt_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   last_i,
    input  logic               fall_i,
    output logic               sdata_o,
    output logic               sclk_o,
    output logic               start_o,
    output logic               done_o
);

    localparam int unsigned PH_W    = $clog2(CLK_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);

    typedef struct packed {
        logic               active;
        logic               hold;
        fmt_e               fmt;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   idx;
        logic [CNT_W-1:0]   last;
        logic [PH_W-1:0]    phase;
    } shf_st_t;

    shf_st_t s_d, s_q;
    logic    advance;

    assign start_o = !s_q.active && !s_q.hold && !cs_n_i && ready_i;

    always_comb begin
        s_d     = s_q;
        done_o  = 1'b0;
        advance = 1'b0;
        if (cs_n_i) s_d.hold = 1'b0;
        if (s_q.active) begin
            if (s_q.fmt == FMT_SELF) advance = (s_q.phase == PH_LAST);
            else                     advance = fall_i;
            if (cs_n_i) begin
                s_d.active = 1'b0;
            end else begin
                if (s_q.fmt == FMT_SELF)
                    s_d.phase = (s_q.phase == PH_LAST) ? '0 : s_q.phase + PH_W'(1);
                if (advance) begin
                    if (s_q.idx == s_q.last) begin
                        s_d.active = 1'b0;
                        s_d.hold   = 1'b1;
                        done_o     = 1'b1;
                    end else begin
                        s_d.idx   = s_q.idx + CNT_W'(1);
                        s_d.shreg = s_q.shreg >> 1;
                    end
                end
            end
        end else if (start_o) begin
            s_d.active = 1'b1;
            s_d.fmt    = fmt_e'(fmt_i);
            s_d.shreg  = frame_i;
            s_d.idx    = '0;
            s_d.last   = last_i;
            s_d.phase  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdata_o = s_q.active ? s_q.shreg[0] : (fmt_i == FMT_ASYNC);
    assign sclk_o  = s_q.active && (s_q.fmt == FMT_SELF) && (s_q.phase == PH_W'(1));

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import srp_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned BLANK_CYC   = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CLK_DIV     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [WORD_W-1:0] load_data,
    input  logic [1:0]        fmt_sel,
    input  logic              cs_n,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdata,
    output logic              drdy_n
);

    localparam int unsigned NBYTES  = WORD_W / 8;
    localparam int unsigned FRAME_W = NBYTES * BYTE_SLOT;
    localparam int unsigned CNT_W   = $clog2(FRAME_W);

    logic                ext_fall;
    logic                ready;
    logic                xfer_start;
    logic                xfer_done;
    logic [WORD_W-1:0]   held_word;
    logic [FRAME_W-1:0]  frame;
    logic [CNT_W-1:0]    last_idx;

    srp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sclk_in),
        .fall_o (ext_fall)
    );

    srp_ready_track #(.WORD_W(WORD_W), .BLANK_CYC(BLANK_CYC)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_valid),
        .data_i  (load_data),
        .start_i (xfer_start),
        .done_i  (xfer_done),
        .word_o  (held_word),
        .ready_o (ready)
    );

    srp_frame_build #(.WORD_W(WORD_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
        .word_i  (held_word),
        .fmt_i   (fmt_sel),
        .frame_o (frame),
        .last_o  (last_idx)
    );

    srp_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (cs_n),
        .ready_i (ready),
        .fmt_i   (fmt_sel),
        .frame_i (frame),
        .last_i  (last_idx),
        .fall_i  (ext_fall),
        .sdata_o (sdata),
        .sclk_o  (sclk_out),
        .start_o (xfer_start),
        .done_o  (xfer_done)
    );

    assign sclk_oe = (fmt_sel == FMT_SELF);
    assign drdy_n  = ~ready;

endmodule

// File: rtl/srp_chk.sv
module srp_chk (
    input logic clk,
    input logic rst_n,
    input logic load_valid,
    input logic cs_n,
    input logic drdy_n,
    input logic sclk_out,
    input logic xfer_start,
    input logic xfer_done
);

    // R2
    load_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> drdy_n);

    // R3
    start_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !drdy_n);

    // R6
    sclk_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |=> !sclk_out ##1 !sclk_out);

    // R9
    abort_stops_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sclk_out);

    // R7
    drdy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy_n) |-> ($past(load_valid) || $past(xfer_done)));

endmodule

bind serial_result_port srp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .cs_n       (cs_n),
    .drdy_n     (drdy_n),
    .sclk_out   (sclk_out),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done)
);

// File: tb/sim_serial_result_port.sv
module sim_serial_result_port;

    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [15:0] load_data = '0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        cs_n = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sclk_out, sclk_oe, sdata, drdy_n;

    int    checks = 0;
    int    errors = 0;
    int    sclk_rises = 0;
    int    sclk_hi = 0;
    logic  per_chk = 1'b0;
    logic  have_rise = 1'b0;
    time   last_rise = 0;
    string cur_req = "R4";
    logic  exp_q[$];

    serial_result_port u0 (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
        .fmt_sel(fmt_sel), .cs_n(cs_n), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .sdata(sdata), .drdy_n(drdy_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_async(input logic [15:0] w, input int n);
        logic b[$];
        for (int k = 1; k >= 0; k--) begin
            b.push_back(1'b0);
            for (int i = 0; i < 8; i++) b.push_back(w[k*8+i]);
            b.push_back(1'b1);
            b.push_back(1'b1);
        end
        for (int i = 0; i < n; i++) exp_q.push_back(b[i]);
    endtask

    task automatic push_sync(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) exp_q.push_back(w[i]);
    endtask

    task automatic load_word(input logic [15:0] w);
        @(negedge clk);
        load_valid = 1'b1;
        load_data  = w;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic sclk_bits(input int n);
        repeat (n) begin
            sclk_in = 1'b1;
            wait_cyc(HALF);
            sclk_in = 1'b0;
            wait_cyc(HALF);
        end
    endtask

    task automatic wait_empty(input int limit);
        for (int i = 0; i < limit && exp_q.size() != 0; i++) wait_cyc(1);
    endtask

    // monitor: pops and compares one expected bit per serial clock rise
    initial begin
        forever begin
            @(posedge sclk_in or posedge sclk_out);
            #1;
            if (sclk_out) begin
                sclk_rises++;
                if (per_chk && have_rise) check("R6 period", 32'($time - last_rise), 32'(4*CLK_PERIOD));
                last_rise = $time;
                have_rise = 1'b1;
            end
            if (exp_q.size() == 0) begin
                check({cur_req, " extra bit"}, 32'(1), 32'(0));
            end else begin
                check(cur_req, 32'(sdata), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (sclk_out) sclk_hi++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 drdy_n", 32'(drdy_n), 32'(1));
        check("R1 sdata", 32'(sdata), 32'(1));
        check("R1 sclk_out", 32'(sclk_out), 32'(0));
        check("R1 sclk_oe", 32'(sclk_oe), 32'(0));

        // R2: four-cycle blanking window
        load_word(16'hA5C3);
        check("R2 blank0", 32'(drdy_n), 32'(1));
        for (int i = 1; i < 4; i++) begin
            wait_cyc(1);
            check("R2 blank", 32'(drdy_n), 32'(1));
        end
        wait_cyc(1);
        check("R2 ready", 32'(drdy_n), 32'(0));

        // R4: framed asynchronous word
        cur_req = "R4";
        push_async(16'hA5C3, 22);
        cs_n = 1'b0;
        wait_cyc(3);
        sclk_bits(22);
        wait_cyc(6);
        check("R4 all bits", 32'(exp_q.size()), 32'(0));
        check("R4 idle", 32'(sdata), 32'(1));
        check("R7 done", 32'(drdy_n), 32'(1));
        cs_n = 1'b1;
        wait_cyc(2);

        // R5: external clock, raw MSB first, codes 01 and 11
        cur_req = "R5";
        fmt_sel = 2'b01;
        load_word(16'h3C96);
        wait_cyc(5);
        push_sync(16'h3C96);
        cs_n = 1'b0;
        wait_cyc(3);
        sclk_bits(16);
        wait_cyc(6);
        check("R5 all bits", 32'(exp_q.size()), 32'(0));
        check("R5 idle", 32'(sdata), 32'(0));
        check("R7 done", 32'(drdy_n), 32'(1));
        cs_n = 1'b1;
        fmt_sel = 2'b11;
        load_word(16'h8001);
        wait_cyc(5);
        push_sync(16'h8001);
        cs_n = 1'b0;
        wait_cyc(3);
        sclk_bits(16);
        wait_cyc(6);
        check("R5 code11", 32'(exp_q.size()), 32'(0));
        cs_n = 1'b1;
        wait_cyc(2);

        // R6: self-clocked
        cur_req = "R6";
        fmt_sel = 2'b10;
        wait_cyc(1);
        check("R6 sclk_oe", 32'(sclk_oe), 32'(1));
        load_word(16'hF00D);
        wait_cyc(5);
        push_sync(16'hF00D);
        sclk_hi = 0;
        sclk_rises = 0;
        have_rise = 1'b0;
        per_chk = 1'b1;
        cs_n = 1'b0;
        wait_empty(200);
        wait_cyc(8);
        per_chk = 1'b0;
        check("R6 all bits", 32'(exp_q.size()), 32'(0));
        check("R6 rises", 32'(sclk_rises), 32'(16));
        check("R6 high cycles", 32'(sclk_hi), 32'(16));
        check("R7 done", 32'(drdy_n), 32'(1));

        // R10: no restart while cs_n stays low
        cur_req = "R10";
        sclk_rises = 0;
        load_word(16'h1234);
        wait_cyc(10);
        check("R10 no restart", 32'(sclk_rises), 32'(0));
        check("R10 pending", 32'(drdy_n), 32'(0));
        cs_n = 1'b1;
        wait_cyc(2);
        push_sync(16'h1234);
        cs_n = 1'b0;
        wait_empty(200);
        wait_cyc(8);
        check("R10 after reselect", 32'(exp_q.size()), 32'(0));
        cs_n = 1'b1;
        wait_cyc(2);

        // R3: select during blanking waits for ready
        cur_req = "R3";
        load_word(16'h5A0F);
        cs_n = 1'b0;
        sclk_rises = 0;
        push_sync(16'h5A0F);
        for (int i = 0; i < 10 && drdy_n; i++) wait_cyc(1);
        check("R3 waited", 32'(sclk_rises), 32'(0));
        wait_empty(200);
        wait_cyc(8);
        check("R3 all bits", 32'(exp_q.size()), 32'(0));
        cs_n = 1'b1;
        wait_cyc(2);

        // R8 / R7: load in the middle of a word
        cur_req = "R8";
        fmt_sel = 2'b01;
        load_word(16'hC0DE);
        wait_cyc(5);
        push_sync(16'hC0DE);
        cs_n = 1'b0;
        wait_cyc(3);
        sclk_bits(8);
        load_word(16'hBEEF);
        check("R2 mid-transfer", 32'(drdy_n), 32'(1));
        wait_cyc(5);
        check("R2 mid-transfer ready", 32'(drdy_n), 32'(0));
        sclk_bits(8);
        wait_cyc(6);
        check("R8 old word intact", 32'(exp_q.size()), 32'(0));
        check("R7 newer kept", 32'(drdy_n), 32'(0));
        cs_n = 1'b1;
        wait_cyc(2);
        push_sync(16'hBEEF);
        cs_n = 1'b0;
        wait_cyc(3);
        sclk_bits(16);
        wait_cyc(6);
        check("R8 new word sent", 32'(exp_q.size()), 32'(0));
        check("R7 done", 32'(drdy_n), 32'(1));
        cs_n = 1'b1;
        wait_cyc(2);

        // R9: abort and restart
        cur_req = "R9";
        fmt_sel = 2'b00;
        wait_cyc(1);
        load_word(16'h6B2D);
        wait_cyc(5);
        push_async(16'h6B2D, 7);
        cs_n = 1'b0;
        wait_cyc(3);
        sclk_bits(7);
        cs_n = 1'b1;
        wait_cyc(3);
        check("R9 idle", 32'(sdata), 32'(1));
        check("R9 drdy kept", 32'(drdy_n), 32'(0));
        check("R9 partial", 32'(exp_q.size()), 32'(0));
        push_async(16'h6B2D, 22);
        cs_n = 1'b0;
        wait_cyc(3);
        sclk_bits(22);
        wait_cyc(6);
        check("R9 restart", 32'(exp_q.size()), 32'(0));
        check("R7 done", 32'(drdy_n), 32'(1));
        cs_n = 1'b1;
        wait_cyc(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule